// File: doc/BRIEF.md
# Three-Wire Control Register Port

This block receives configuration from a host over three plain lines: a serial data line, a serial bit clock and a latch strobe. It collects 16-bit words, most significant bit first. When the latch strobe rises, the block stores the word in one of four configuration registers. Two address bits inside the word pick the register. The stored fields drive the rest of the converter directly as decoded outputs:

- per-channel attenuation codes with their load flags;
- soft mute, de-emphasis and the operation-off control;
- word length and output routing mode;
- serial format and left/right polarity;
- common attenuation, clock ratio, rate multiple, rate family and zero-detect enable.

The three control lines are asynchronous to the system clock. They pass through synchronizers, and their edges are detected in the system clock domain.

The block also sequences the reset of the neighbouring function blocks. Once the system reset is released, `func_rst` stays high for a fixed number of system clocks. While it is high, those blocks hold their outputs at the mid-scale zero level.

Top module: `ctl3w_port`

## Requirements
- R1: Bits are sampled on each rising edge of `ctl_clk`, most significant bit first. A rising edge of `ctl_latch` commits a word once at least 16 bits have been clocked since the previous latch. The committed word is the last 16 bits clocked.
- R2: Word bits 10:9 select the register: 0 is left attenuation, 1 is right attenuation, 2 is the mode register and 3 is the format register. Only the selected register changes. Bits 15:11 have no effect.
- R3: In register 0, bits 7:0 drive `att_left` and bit 8 drives `ld_left`.
- R4: In register 1, bits 7:0 drive `att_right` and bit 8 drives `ld_right`.
- R5: In register 2, the bits drive these outputs:
  - bit 0 drives `mute`;
  - bit 1 drives `deemph`;
  - bit 2 drives `op_off`;
  - bits 4:3 drive `word_len`;
  - bits 8:5 drive `out_mode`.
- R6: In register 3, the bits drive these outputs:
  - bit 0 drives `fmt_i2s`;
  - bit 1 drives `lr_pol`;
  - bit 2 drives `att_common`;
  - bit 3 drives `clk_256` (0 means 384 times the sample rate, 1 means 256 times);
  - bits 5:4 drive `rate_mult` (00 normal, 01 double, 10 half, 11 reserved);
  - bits 7:6 drive `rate_grp` (00 is the 44.1 kHz family, 01 the 48 kHz family, 10 the 32 kHz family, 11 reserved);
  - bit 8 drives `zero_det_en`.
- R7: A latch edge after fewer than 16 clocked bits changes no register. It also clears the bit count, so the next word starts afresh.
- R8: Bits clocked without a following latch edge change no register.
- R9: Reset sets these values:
  - register 0 = 0x0FF;
  - register 1 = 0x0FF;
  - register 2 = 0x120, which gives output mode 1001 (stereo) with all other fields 0;
  - register 3 = 0x000.
- R10: `func_rst` is high while `rst` is high. It stays high for exactly 1024 clocks after `rst` falls and then stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_data | input | 1 | Serial control data (asynchronous) |
| ctl_clk | input | 1 | Serial control bit clock (asynchronous) |
| ctl_latch | input | 1 | Word commit strobe (asynchronous) |
| att_left | output | 8 | Left attenuation code |
| att_right | output | 8 | Right attenuation code |
| ld_left | output | 1 | Left attenuation load flag |
| ld_right | output | 1 | Right attenuation load flag |
| mute | output | 1 | Soft mute request |
| deemph | output | 1 | De-emphasis enable |
| op_off | output | 1 | Force outputs to mid-scale |
| word_len | output | 2 | Input word length code |
| out_mode | output | 4 | Output routing mode |
| fmt_i2s | output | 1 | Serial audio format select |
| lr_pol | output | 1 | Word clock polarity |
| att_common | output | 1 | Use left attenuation on both channels |
| clk_256 | output | 1 | Clock ratio select |
| rate_mult | output | 2 | Sample rate multiple |
| rate_grp | output | 2 | Sample rate family |
| zero_det_en | output | 1 | Zero detection enable |
| func_rst | output | 1 | Reset to the function blocks |

## Verification
A wrong bit count, or a wrong shift order, shows up as a field landing in the wrong register or at the wrong bit position. It becomes visible on the decoded outputs a few clocks after the latch edge that commits the word. A count that does not clear, or a stale edge detector, makes a short or unlatched sequence overwrite a register. This is caught by comparing every output against a model of all four registers after each stimulus. A wrong reset counter moves the falling edge of `func_rst`, which is checked on the exact clock where it must fall.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;

    localparam int FRAME_BITS = 16;
    localparam int ADDR_LSB   = 9;
    localparam int ADDR_W     = 2;
    localparam int FIELD_W    = ADDR_LSB;
    localparam int PAYLOAD_W  = ADDR_LSB + ADDR_W;
    localparam int NREG       = 1 << ADDR_W;

    typedef enum logic [ADDR_W-1:0] {
        REG_ATT_L = 2'd0,
        REG_ATT_R = 2'd1,
        REG_MODE  = 2'd2,
        REG_FMT   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        RMUL_NORMAL = 2'd0,
        RMUL_DOUBLE = 2'd1,
        RMUL_HALF   = 2'd2,
        RMUL_RSVD   = 2'd3
    } rate_mult_e;

    typedef enum logic [1:0] {
        RGRP_44K1 = 2'd0,
        RGRP_48K  = 2'd1,
        RGRP_32K  = 2'd2,
        RGRP_RSVD = 2'd3
    } rate_grp_e;

    typedef struct packed {
        logic       load;
        logic [7:0] code;
    } att_t;

    typedef struct packed {
        logic [3:0] out_mode;
        logic [1:0] word_len;
        logic       op_off;
        logic       deemph;
        logic       mute;
    } mode_t;

    typedef struct packed {
        logic       zero_det;
        rate_grp_e  rate_grp;
        rate_mult_e rate_mult;
        logic       clk_256;
        logic       att_common;
        logic       lr_pol;
        logic       i2s;
    } fmt_t;

    function automatic logic [FIELD_W-1:0] reg_default(input int idx);
        att_t  a;
        mode_t m;
        fmt_t  f;
        a = '{load: 1'b0, code: 8'hFF};
        m = '{out_mode: 4'b1001, word_len: 2'b00, op_off: 1'b0, deemph: 1'b0, mute: 1'b0};
        f = '{zero_det: 1'b0, rate_grp: RGRP_44K1, rate_mult: RMUL_NORMAL,
              clk_256: 1'b0, att_common: 1'b0, lr_pol: 1'b0, i2s: 1'b0};
        case (idx)
            0, 1:    return a;
            2:       return m;
            default: return f;
        endcase
    endfunction

endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
    parameter int LINES  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= '0;
            else     pipe <= {pipe[STAGES-2:0], din[i]};
        end
        assign dout[i] = pipe[STAGES-1];
    end

endmodule

// File: rtl/ctl3w_shift.sv
module ctl3w_shift
    import ctl3w_pkg::*;
#(
    parameter int FRAME_LEN = FRAME_BITS,
    parameter int WORD_W    = PAYLOAD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              data_s,
    input  logic              sclk_s,
    input  logic              latch_s,
    output logic              commit,
    output logic [WORD_W-1:0] word
);

    localparam int CNT_W = $clog2(FRAME_LEN + 1);

    logic              sclk_d, latch_d;
    logic              sclk_rise, latch_rise;
    logic [WORD_W-1:0] sr;
    logic [CNT_W-1:0]  cnt;

    assign sclk_rise  = sclk_s & ~sclk_d;
    assign latch_rise = latch_s & ~latch_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d  <= 1'b0;
            latch_d <= 1'b0;
            sr      <= '0;
            cnt     <= '0;
            commit  <= 1'b0;
            word    <= '0;
        end else begin
            sclk_d  <= sclk_s;
            latch_d <= latch_s;
            commit  <= latch_rise && (cnt == CNT_W'(FRAME_LEN));
            if (latch_rise) begin
                word <= sr;
                cnt  <= '0;
            end else if (sclk_rise) begin
                sr <= {sr[WORD_W-2:0], data_s};
                if (cnt != CNT_W'(FRAME_LEN)) cnt <= cnt + 1'b1;
            end
        end
    end

    AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit); // R1

endmodule

// File: rtl/ctl3w_regfile.sv
module ctl3w_regfile
    import ctl3w_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 commit,
    input  logic [PAYLOAD_W-1:0] word,
    output att_t                 att_l,
    output att_t                 att_r,
    output mode_t                mode,
    output fmt_t                 fmt
);

    logic [ADDR_W-1:0]  addr;
    logic [FIELD_W-1:0] regs [NREG];

    assign addr = word[PAYLOAD_W-1:FIELD_W];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                                        regs[g] <= reg_default(g);
            else if (commit && (addr == ADDR_W'(g)))        regs[g] <= word[FIELD_W-1:0];
        end
    end

    assign att_l = att_t'(regs[REG_ATT_L]);
    assign att_r = att_t'(regs[REG_ATT_R]);
    assign mode  = mode_t'(regs[REG_MODE]);
    assign fmt   = fmt_t'(regs[REG_FMT]);

    AST_RESET_DEFAULTS: assert property (@(posedge clk)
        rst |=> (regs[0] == 9'h0FF && regs[1] == 9'h0FF && regs[2] == 9'h120 && regs[3] == 9'h000)); // R9

    AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(regs[0]) && $stable(regs[1]) && $stable(regs[2]) && $stable(regs[3]))); // R8

    AST_ONE_REG_WRITE: assert property (@(posedge clk) disable iff (rst)
        commit |=> ($countones({regs[0] != $past(regs[0]), regs[1] != $past(regs[1]),
                                regs[2] != $past(regs[2]), regs[3] != $past(regs[3])}) <= 1)); // R2

endmodule

// File: rtl/ctl3w_rstseq.sv
module ctl3w_rstseq #(
    parameter int HOLD_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst,
    output logic func_rst
);

    localparam int CW = $clog2(HOLD_CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                          cnt <= '0;
        else if (cnt != CW'(HOLD_CYCLES)) cnt <= cnt + 1'b1;
    end

    assign func_rst = (cnt != CW'(HOLD_CYCLES));

    AST_HOLD_IN_RESET: assert property (@(posedge clk)
        rst |=> func_rst); // R10

    AST_RELEASE_STICKS: assert property (@(posedge clk) disable iff (rst)
        !func_rst |=> !func_rst); // R10

endmodule

// File: rtl/ctl3w_port.sv
module ctl3w_port
    import ctl3w_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_data,
    input  logic       ctl_clk,
    input  logic       ctl_latch,
    output logic [7:0] att_left,
    output logic [7:0] att_right,
    output logic       ld_left,
    output logic       ld_right,
    output logic       mute,
    output logic       deemph,
    output logic       op_off,
    output logic [1:0] word_len,
    output logic [3:0] out_mode,
    output logic       fmt_i2s,
    output logic       lr_pol,
    output logic       att_common,
    output logic       clk_256,
    output logic [1:0] rate_mult,
    output logic [1:0] rate_grp,
    output logic       zero_det_en,
    output logic       func_rst
);

    logic [2:0]           lines_s;
    logic                 commit;
    logic [PAYLOAD_W-1:0] word;
    att_t                 att_l, att_r;
    mode_t                mode;
    fmt_t                 fmt;

    ctl3w_sync #(.LINES(3), .STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ctl_latch, ctl_clk, ctl_data}),
        .dout (lines_s)
    );

    ctl3w_shift #(.FRAME_LEN(FRAME_BITS), .WORD_W(PAYLOAD_W)) i_shift (
        .clk     (clk),
        .rst     (rst),
        .data_s  (lines_s[0]),
        .sclk_s  (lines_s[1]),
        .latch_s (lines_s[2]),
        .commit  (commit),
        .word    (word)
    );

    ctl3w_regfile i_regs (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .word   (word),
        .att_l  (att_l),
        .att_r  (att_r),
        .mode   (mode),
        .fmt    (fmt)
    );

    ctl3w_rstseq #(.HOLD_CYCLES(HOLD_CYCLES)) i_rstseq (
        .clk      (clk),
        .rst      (rst),
        .func_rst (func_rst)
    );

    assign att_left    = att_l.code;
    assign ld_left     = att_l.load;
    assign att_right   = att_r.code;
    assign ld_right    = att_r.load;
    assign mute        = mode.mute;
    assign deemph      = mode.deemph;
    assign op_off      = mode.op_off;
    assign word_len    = mode.word_len;
    assign out_mode    = mode.out_mode;
    assign fmt_i2s     = fmt.i2s;
    assign lr_pol      = fmt.lr_pol;
    assign att_common  = fmt.att_common;
    assign clk_256     = fmt.clk_256;
    assign rate_mult   = fmt.rate_mult;
    assign rate_grp    = fmt.rate_grp;
    assign zero_det_en = fmt.zero_det;

endmodule

// File: tb/test_ctl3w_port.sv
module test_ctl3w_port;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_data = 1'b0, ctl_clk = 1'b0, ctl_latch = 1'b0;
    logic [7:0] att_left, att_right;
    logic ld_left, ld_right, mute, deemph, op_off, fmt_i2s, lr_pol, att_common, clk_256, zero_det_en, func_rst;
    logic [1:0] word_len, rate_mult, rate_grp;
    logic [3:0] out_mode;

    int checks = 0;
    int failures = 0;
    logic [8:0] model [4];

    always #4 clk = ~clk;

    ctl3w_port i_ctl3w_port (
        .clk(clk), .rst(rst), .ctl_data(ctl_data), .ctl_clk(ctl_clk), .ctl_latch(ctl_latch),
        .att_left(att_left), .att_right(att_right), .ld_left(ld_left), .ld_right(ld_right),
        .mute(mute), .deemph(deemph), .op_off(op_off), .word_len(word_len), .out_mode(out_mode),
        .fmt_i2s(fmt_i2s), .lr_pol(lr_pol), .att_common(att_common), .clk_256(clk_256),
        .rate_mult(rate_mult), .rate_grp(rate_grp), .zero_det_en(zero_det_en), .func_rst(func_rst)
    );

    function automatic logic [35:0] expected_bus();
        return {model[0][7:0], model[1][7:0], model[0][8], model[1][8], model[2], model[3]};
    endfunction

    function automatic logic [35:0] actual_bus();
        return {att_left, att_right, ld_left, ld_right, out_mode, word_len, op_off, deemph, mute,
                zero_det_en, rate_grp, rate_mult, clk_256, att_common, lr_pol, fmt_i2s};
    endfunction

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_fields(input string req);
        check(req, actual_bus(), expected_bus());
    endtask

    task automatic model_reset();
        model[0] = 9'h0FF; model[1] = 9'h0FF; model[2] = 9'h120; model[3] = 9'h000;
    endtask

    task automatic send_bits(input logic [15:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk); ctl_data = w[i]; ctl_clk = 1'b0;
            repeat (3) @(negedge clk);
            ctl_clk = 1'b1;
            repeat (3) @(negedge clk);
        end
        ctl_clk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_latch();
        @(negedge clk); ctl_latch = 1'b1;
        repeat (4) @(negedge clk);
        ctl_latch = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic write_word(input logic [15:0] w);
        send_bits(w, 16);
        pulse_latch();
        model[w[10:9]] = w[8:0];
    endtask

    task automatic reset_and_release();
        @(negedge clk); rst = 1'b1;
        repeat (5) @(negedge clk);
        model_reset();
        check("R9 defaults", actual_bus(), expected_bus());
        check("R10 func_rst in reset", {35'd0, func_rst}, 36'd1);
        rst = 1'b0;
        repeat (1023) @(posedge clk);
        @(negedge clk);
        check("R10 func_rst held 1023", {35'd0, func_rst}, 36'd1);
        @(posedge clk); @(negedge clk);
        check("R10 func_rst released 1024", {35'd0, func_rst}, 36'd0);
        repeat (20) @(negedge clk);
        check("R10 func_rst stays low", {35'd0, func_rst}, 36'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        string tags [4];
        logic [15:0] w;
        int n;
        tags[0] = "R3"; tags[1] = "R4"; tags[2] = "R5"; tags[3] = "R6";
        void'($urandom(32'h5EED_0C3A));
        reset_and_release();

        // directed: each register with distinct patterns
        write_word(16'h0000 | 9'h1A5);                 check_fields("R3 left att+load");
        write_word(16'h0200 | 9'h05A);                 check_fields("R4 right att");
        write_word(16'h0400 | 9'b1100_10_1_0_1);       check_fields("R5 mode fields");
        write_word(16'h0600 | 9'b1_10_01_1_0_1_0);     check_fields("R6 fmt fields");
        // reserved bits all set
        write_word(16'hF800 | 16'h0400 | 9'h0F3);      check_fields("R2 reserved bits ignored");

        // short frame ignored
        for (int k = 0; k < 4; k++) begin
            n = 1 + ($urandom % 15);
            send_bits(16'hFFFF, n);
            pulse_latch();
            check_fields("R7 short frame ignored");
        end
        // count cleared: a full word after a short one lands normally
        send_bits(16'h0003, 7); pulse_latch();
        write_word(16'h0200 | 9'h133);                 check_fields("R7 next frame after short");

        // bits without latch change nothing
        send_bits(16'h07FF, 10);
        check_fields("R8 no latch no change");
        // then a full word: only last 16 bits count
        w = 16'h0000 | 9'h07E;
        send_bits(w, 16);
        pulse_latch();
        model[0] = w[8:0];
        check_fields("R1 last 16 bits committed");

        // random words
        for (int k = 0; k < 40; k++) begin
            w = 16'($urandom);
            write_word(w);
            check_fields($sformatf("R1/R2/%s random addr %0d", tags[w[10:9]], w[10:9]));
        end

        // rate codes corner values
        write_word(16'h0600 | 9'b0_11_11_0_0_0_0);     check_fields("R6 reserved rate codes");
        write_word(16'h0600 | 9'b1_10_10_1_1_1_1);     check_fields("R6 half rate 32k group");

        // reset mid-run restores defaults
        reset_and_release();
        write_word(16'h0400 | 9'h000);                 check_fields("R5 all clear");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule